// File: doc/BRIEF.md
# Programmable Asynchronous External Bus Sequencer

This block turns single internal transfer requests into timed cycles on an asynchronous external bus with four chip-select regions. Each region has a 32-bit configuration word. The word sets the setup, strobe and hold lengths in clock cycles, separately for reads and for writes. It also enables an optional stretch of the strobe by an active-low ready input, chooses whether that ready input is resynchronised through two flops or sampled through one, and sets the data width of the region.

A requester may present a transfer only while `req_idle` is high. The block then drives the chip select of the chosen region low, along with either the read strobe or the write strobe. It holds the address and write data steady for the whole cycle. In the last cycle of the hold phase it pulses `done` for one cycle, and for a read it presents the captured data zero-extended to 32 bits. The configuration words are written and read through a simple word-addressed port.

Top module: `async_bus_seq`

## Requirements
- R1: After reset, the four configuration words at byte offsets 0x10, 0x14, 0x18 and 0x1C (regions 0 to 3) read 0x3FFF_FFF2, and any other offset reads zero.
- R2: Bits [3:2] of each configuration word are reserved: they always read as zero, and writes to them have no effect.
- R3: For a read, chip select is low and the read strobe high for (bits[16:13]+1) cycles. The read strobe is then low for (bits[12:7]+1) cycles. The hold phase then lasts (bits[6:4]+1) cycles before chip select rises. The write strobe stays high throughout.
- R4: For a write, the setup, strobe and hold lengths are (bits[29:26]+1), (bits[25:20]+1) and (bits[19:17]+1) cycles. `ext_dout_en` is high for the whole cycle, and the read strobe stays high.
- R5: Only chip-select bit `req_bank` goes low during a transfer. The address stays equal to `req_addr` while chip select is low.
- R6: `done` is high for exactly one cycle, in the last cycle of the hold phase, and chip select is high in the next cycle.
- R7: Bits [1:0] set the width: 00 is 8 bits, 01 is 16 bits, and 10 or 11 is 32 bits. Read data keeps only that many low bits of `ext_din`, with the upper bits zero. Write data on `ext_dout` is masked in the same way.
- R8: When bit 30 is 1, the strobe lasts the programmed count and then stays low until ready is seen. If ready is already active, the strobe is exactly the programmed length.
- R9: When bit 31 is 1, ready passes through one register stage. When it is 0, it passes through two. If ready asserts in strobe cycle k, past the programmed count, the strobe ends after k+1 cycles when bit 31 is 1 and after k+2 cycles when it is 0.
- R10: When bit 30 is 0, `ext_rdy_n` has no effect on the strobe length.
- R11: A request made while a transfer is running is dropped: no chip select of another region goes low, and no extra `done` follows.
- R12: The configuration of a region is taken when its transfer is accepted. A write to that region's word during the transfer changes the next transfer only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word at cfg_addr |
| req_valid | input | 1 | Transfer request, taken when req_idle is high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | BW | Chip-select region |
| req_addr | input | AW | External address |
| req_wdata | input | 32 | Write data |
| req_idle | output | 1 | Sequencer idle, a request would be taken |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | 32 | Read data, valid with done |
| ext_cs_n | output | NBANK | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_addr | output | AW | External address |
| ext_dout | output | 32 | External write data |
| ext_dout_en | output | 1 | Write data drive enable |
| ext_din | input | 32 | External read data |
| ext_rdy_n | input | 1 | Active-low ready from the device |

## Verification
The hardest situations to reach are those where the ready stretch and the resynchroniser depth interact. The strobe length then depends on which strobe cycle ready arrives in, relative to the programmed count. The bench drives ready from inside its bus monitor, at an exact strobe-cycle index, and compares the one-stage and two-stage lengths. It also starts a transfer with ready already asserted, to show that the programmed minimum holds. Requests and configuration writes made during a transfer are injected from the same monitor, so they land in a known phase.

// File: rtl/async_bus_pkg.sv
// Package: shared types and helpers for the asynchronous bus sequencer.
// Assumes a 32-bit internal data path; field positions are fixed by the
// configuration word layout that software programs.
package async_bus_pkg;

    localparam int          DW        = 32;
    localparam logic [31:0] CFG_RESET = 32'h3FFF_FFF2;
    localparam int          CFG_BASE  = 'h10;

    // One region's configuration word, packed MSB first.
    typedef struct packed {
        logic       rdy_sync;   // [31]    1: ready sampled through one stage
        logic       rdy_wait;   // [30]    1: strobe stretched by ready
        logic [3:0] w_su;       // [29:26]
        logic [5:0] w_stb;      // [25:20]
        logic [2:0] w_hld;      // [19:17]
        logic [3:0] r_su;       // [16:13]
        logic [5:0] r_stb;      // [12:7]
        logic [2:0] r_hld;      // [6:4]
        logic [1:0] rsvd;       // [3:2]
        logic [1:0] width;      // [1:0]   00: 8, 01: 16, 1x: 32 bits
    } bank_cfg_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_SETUP, SQ_STROBE, SQ_WAIT, SQ_HOLD
    } seq_state_t;

    // Keeps only the bytes that a region of the given width carries.
    function automatic logic [DW-1:0] lane_mask(input logic [DW-1:0] d,
                                                input logic [1:0] w);
        logic [DW-1:0] r;
        unique case (w)
            2'b00:   r = {24'h0, d[7:0]};
            2'b01:   r = {16'h0, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/async_bus_cfg_regs.sv
// Module: holds one configuration word per chip-select region.
// Assumes byte offsets CFG_BASE + 4*i; reserved bits [3:2] are stored as 0.
module async_bus_cfg_regs
    import async_bus_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int CFG_AW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [31:0]                 cfg_wdata,
    output logic [31:0]                 cfg_rdata,
    output bank_cfg_t [NBANK-1:0]       cfg_q
);

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        localparam int OFFS = CFG_BASE + 4 * i;
        logic hit;
        assign hit = (int'(cfg_addr) == OFFS);

        // Store a new word on a write hit, with the reserved bits cleared.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= bank_cfg_t'(CFG_RESET);
            end else if (cfg_we && hit) begin
                cfg_q[i] <= bank_cfg_t'({cfg_wdata[31:4], 2'b00, cfg_wdata[1:0]});
            end
        end
    end

    // Return the word at the addressed offset, zero elsewhere.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (int'(cfg_addr) == CFG_BASE + 4 * i) cfg_rdata = cfg_q[i];
        end
    end

endmodule

// File: rtl/async_bus_rdy_sync.sv
// Module: brings the active-low ready input into the clock domain.
// Assumes the chain runs continuously; sel_one picks the first stage
// (synchronous device) or the second (asynchronous device).
module async_bus_rdy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n_in,
    input  logic sel_one,
    output logic rdy_act
);

    logic stage1_n, stage2_n;

    // Shift ready through two flops; both reset to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_n <= 1'b1;
            stage2_n <= 1'b1;
        end else begin
            stage1_n <= rdy_n_in;
            stage2_n <= stage1_n;
        end
    end

    // Pick the tap that the region's mode asks for.
    assign rdy_act = sel_one ? !stage1_n : !stage2_n;

endmodule

// File: rtl/async_bus_fsm.sv
// Module: sequences one external transfer through setup, strobe, an
// optional ready wait, and hold. Assumes the region's configuration is
// valid on cfg_sel in the cycle the request is taken; it is copied then.
module async_bus_fsm
    import async_bus_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 24,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BW-1:0]    req_bank,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  bank_cfg_t        cfg_sel,
    input  logic             rdy_act,
    input  logic [DW-1:0]    ext_din,
    output logic             rdy_one_stage,
    output logic             req_idle,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [NBANK-1:0] ext_cs_n,
    output logic             ext_rd_n,
    output logic             ext_wr_n,
    output logic [AW-1:0]    ext_addr,
    output logic [DW-1:0]    ext_dout,
    output logic             ext_dout_en
);

    seq_state_t state;
    logic [5:0] cnt;
    logic [BW-1:0] bank_q;
    logic write_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    bank_cfg_t cfg_l;
    logic strobe_on, active, cnt_zero;
    logic [5:0] hold_len, stb_len;

    assign cnt_zero = (cnt == '0);
    assign hold_len = write_q ? {3'b0, cfg_l.w_hld} : {3'b0, cfg_l.r_hld};
    assign stb_len  = write_q ? cfg_l.w_stb : cfg_l.r_stb;

    // Step the phase machine and its down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            cnt     <= '0;
            bank_q  <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            cfg_l   <= bank_cfg_t'(CFG_RESET);
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        bank_q  <= req_bank;
                        write_q <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        cfg_l   <= cfg_sel;
                        cnt     <= req_write ? {2'b0, cfg_sel.w_su} : {2'b0, cfg_sel.r_su};
                        state   <= SQ_SETUP;
                    end
                end
                SQ_SETUP: begin
                    if (cnt_zero) begin
                        cnt   <= stb_len;
                        state <= SQ_STROBE;
                    end else begin
                        cnt <= cnt - 6'd1;
                    end
                end
                SQ_STROBE: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 6'd1;
                    end else if (!cfg_l.rdy_wait || rdy_act) begin
                        if (!write_q) rdata_q <= lane_mask(ext_din, cfg_l.width);
                        cnt   <= hold_len;
                        state <= SQ_HOLD;
                    end else begin
                        state <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (rdy_act) begin
                        if (!write_q) rdata_q <= lane_mask(ext_din, cfg_l.width);
                        cnt   <= hold_len;
                        state <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (cnt_zero) state <= SQ_IDLE;
                    else          cnt   <= cnt - 6'd1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode bus pins from the phase and the latched transfer.
    always_comb begin
        active    = (state != SQ_IDLE);
        strobe_on = (state == SQ_STROBE) || (state == SQ_WAIT);
        ext_cs_n  = '1;
        if (active) ext_cs_n[bank_q] = 1'b0;
    end

    assign ext_rd_n      = !(strobe_on && !write_q);
    assign ext_wr_n      = !(strobe_on && write_q);
    assign ext_addr      = addr_q;
    assign ext_dout      = lane_mask(wdata_q, cfg_l.width);
    assign ext_dout_en   = active && write_q;
    assign req_idle      = !active;
    assign done          = (state == SQ_HOLD) && cnt_zero;
    assign rd_data       = rdata_q;
    assign rdy_one_stage = cfg_l.rdy_sync;

endmodule

// File: rtl/async_bus_seq.sv
// Module: top of the asynchronous bus sequencer; joins the configuration
// store, the ready resynchroniser and the phase machine. Assumes a single
// requester that waits for req_idle.
module async_bus_seq
    import async_bus_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int AW     = 24,
    parameter int CFG_AW = 8,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BW-1:0]     req_bank,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_idle,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic [NBANK-1:0]  ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic [AW-1:0]     ext_addr,
    output logic [31:0]       ext_dout,
    output logic              ext_dout_en,
    input  logic [31:0]       ext_din,
    input  logic              ext_rdy_n
);

    bank_cfg_t [NBANK-1:0] cfg_q;
    logic rdy_act, rdy_one_stage;

    async_bus_cfg_regs #(.NBANK(NBANK), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_q(cfg_q)
    );

    async_bus_rdy_sync u_rdy (
        .clk(clk), .rst_n(rst_n), .rdy_n_in(ext_rdy_n),
        .sel_one(rdy_one_stage), .rdy_act(rdy_act)
    );

    async_bus_fsm #(.NBANK(NBANK), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_sel(cfg_q[req_bank]), .rdy_act(rdy_act), .ext_din(ext_din),
        .rdy_one_stage(rdy_one_stage), .req_idle(req_idle), .done(done),
        .rd_data(rd_data), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_addr(ext_addr), .ext_dout(ext_dout),
        .ext_dout_en(ext_dout_en)
    );

endmodule

// File: rtl/async_bus_seq_checker.sv
// Module: temporal properties on the external bus pins of async_bus_seq.
// Assumes it is bound into every instance of the top module.
module async_bus_seq_checker #(
    parameter int NBANK = 4,
    parameter int AW    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] ext_cs_n,
    input logic             ext_rd_n,
    input logic             ext_wr_n,
    input logic [AW-1:0]    ext_addr,
    input logic             done
);

    a_r5_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ext_cs_n) <= 1);

    a_r3_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    a_r3_rd_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_rd_n) |-> $past(!(&ext_cs_n)));

    a_r4_wr_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_wr_n) |-> $past(!(&ext_cs_n)));

    a_r6_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (&ext_cs_n));

    a_r6_done_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ext_rd_n && ext_wr_n && !(&ext_cs_n)));

    a_r5_cs_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&ext_cs_n) && !done) |=> ($stable(ext_cs_n) && $stable(ext_addr)));

endmodule

bind async_bus_seq async_bus_seq_checker #(.NBANK(NBANK), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_addr(ext_addr), .done(done)
);

// File: tb/async_bus_seq_bench.sv
`timescale 1ns/1ps
module async_bus_seq_bench;

    localparam int NBANK = 4;
    localparam int AW    = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_idle, done;
    logic [31:0] rd_data;
    logic [NBANK-1:0] ext_cs_n;
    logic ext_rd_n, ext_wr_n, ext_dout_en;
    logic [AW-1:0] ext_addr;
    logic [31:0] ext_dout;
    logic [31:0] ext_din = '0;
    logic ext_rdy_n = 1'b1;

    always #4 clk = ~clk;

    async_bus_seq u_async_bus_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_idle(req_idle), .done(done),
        .rd_data(rd_data), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_addr(ext_addr), .ext_dout(ext_dout),
        .ext_dout_en(ext_dout_en), .ext_din(ext_din), .ext_rdy_n(ext_rdy_n)
    );

    int n_vec = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input bit sy, input bit ew,
            input logic [3:0] wsu, input logic [5:0] wst, input logic [2:0] wh,
            input logic [3:0] rsu, input logic [5:0] rst, input logic [2:0] rh,
            input logic [1:0] w);
        return {sy, ew, wsu, wst, wh, rsu, rst, rh, 2'b00, w};
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor results of one transfer
    int m_su, m_stb, m_hd, m_done;
    bit m_bad, m_idle_busy, m_done_last;
    logic [31:0] m_rd, m_dout;
    logic [31:0] inj_cfg;
    logic [7:0]  inj_off;

    // inject: 0 none, 1 request to region 3 during strobe, 2 config write
    task automatic run(input int bank, input bit wr, input logic [31:0] data,
                       input int rdy_at, input int inject);
        logic [AW-1:0] a;
        bit inj_on;
        int guard;
        a = AW'(24'h5A0000 | {8'h0, data[15:0]}) ^ AW'(bank);
        m_su = 0; m_stb = 0; m_hd = 0; m_done = 0; m_bad = 0;
        m_idle_busy = 0; m_done_last = 0; m_rd = '0; m_dout = '0;
        inj_on = 0; guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bank = 2'(bank);
        req_addr = a; req_wdata = data; ext_din = data;
        @(negedge clk);
        req_valid = 1'b0;
        while (ext_cs_n[bank] == 1'b0 && guard < 3000) begin
            if (inj_on) begin
                req_valid = 1'b0; cfg_we = 1'b0; inj_on = 0;
            end
            if ((ext_cs_n | (4'b1 << bank)) != 4'hF) m_bad = 1;
            if (ext_addr != a) m_bad = 1;
            if (ext_dout_en != wr) m_bad = 1;
            if ((wr ? ext_rd_n : ext_wr_n) != 1'b1) m_bad = 1;
            if (req_idle) m_idle_busy = 1;
            m_done_last = done;
            if (!(wr ? ext_wr_n : ext_rd_n)) begin
                m_stb++;
                if (wr) m_dout = ext_dout;
                if (rdy_at != 0 && m_stb == rdy_at) ext_rdy_n = 1'b0;
                if (inject == 1 && m_stb == 1) begin
                    req_valid = 1'b1; req_bank = 2'd3; req_write = 1'b0; inj_on = 1;
                end
                if (inject == 2 && m_stb == 1) begin
                    cfg_we = 1'b1; cfg_addr = inj_off; cfg_wdata = inj_cfg; inj_on = 1;
                end
            end else if (m_stb == 0) m_su++;
            else m_hd++;
            if (done) begin
                m_done++;
                m_rd = rd_data;
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0; cfg_we = 1'b0;
        if (rdy_at != 0) ext_rdy_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  bank;
        logic        wr;
        logic [3:0]  su;
        logic [5:0]  st;
        logic [2:0]  hd;
        logic [1:0]  width;
        logic [31:0] data;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 4'd0,  6'd0,  3'd0, 2'b10, 32'hA5A5_1234, 32'hA5A5_1234},
        '{2'd1, 1'b0, 4'd3,  6'd5,  3'd2, 2'b00, 32'hDEAD_BE7F, 32'h0000_007F},
        '{2'd2, 1'b0, 4'd1,  6'd2,  3'd0, 2'b01, 32'h1234_CAFE, 32'h0000_CAFE},
        '{2'd3, 1'b1, 4'd2,  6'd4,  3'd1, 2'b11, 32'h89AB_CDEF, 32'h89AB_CDEF},
        '{2'd0, 1'b1, 4'd0,  6'd0,  3'd0, 2'b00, 32'h1122_3344, 32'h0000_0044},
        '{2'd1, 1'b1, 4'd15, 6'd63, 3'd7, 2'b01, 32'hFFFF_5A5A, 32'h0000_5A5A}
    };

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and idle pins
        for (int i = 0; i < 4; i++) begin
            cfg_addr = 8'(8'h10 + 4 * i);
            #1;
            chk(cfg_rdata == 32'h3FFF_FFF2, "R1 reset word", cfg_rdata, 32'h3FFF_FFF2);
        end
        cfg_addr = 8'h20; #1;
        chk(cfg_rdata == 32'h0, "R1 unmapped offset", cfg_rdata, 32'h0);
        chk({req_idle, done, ext_rd_n, ext_wr_n, ext_cs_n} == {4'b1011, 4'hF},
            "R1 idle pins", 32'({req_idle, done, ext_rd_n, ext_wr_n, ext_cs_n}), 32'hBF);

        // R2: reserved bits
        cfg_write(8'h10, 32'hFFFF_FFFF);
        cfg_addr = 8'h10; #1;
        chk(cfg_rdata == 32'hFFFF_FFF3, "R2 reserved bits", cfg_rdata, 32'hFFFF_FFF3);

        // Table walk: R3, R4, R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            if (t.wr)
                cfg_write(8'(8'h10 + 4 * t.bank),
                          mk(0, 0, t.su, t.st, t.hd, 4'hF, 6'h3F, 3'h7, t.width));
            else
                cfg_write(8'(8'h10 + 4 * t.bank),
                          mk(0, 0, 4'hF, 6'h3F, 3'h7, t.su, t.st, t.hd, t.width));
            run(int'(t.bank), t.wr, t.data, 0, 0);
            chk(m_su == int'(t.su) + 1, t.wr ? "R4 setup" : "R3 setup", 32'(m_su), 32'(t.su + 1));
            chk(m_stb == int'(t.st) + 1, t.wr ? "R4 strobe" : "R3 strobe", 32'(m_stb), 32'(t.st + 1));
            chk(m_hd == int'(t.hd) + 1, t.wr ? "R4 hold" : "R3 hold", 32'(m_hd), 32'(t.hd + 1));
            chk(!m_bad, "R5 pins/address/direction", 32'(m_bad), 0);
            chk(m_done == 1 && m_done_last, "R6 done pulse", 32'(m_done), 1);
            if (t.wr) chk(m_dout == t.expv, "R7 write lanes", m_dout, t.expv);
            else      chk(m_rd == t.expv, "R7 read lanes", m_rd, t.expv);
        end

        // R8, R9: ready arrives in strobe cycle 5, programmed strobe 2
        cfg_write(8'h18, mk(1, 1, 0, 0, 0, 4'd1, 6'd1, 3'd1, 2'b10));
        run(2, 0, 32'h0BAD_F00D, 5, 0);
        chk(m_stb == 6, "R9 one-stage ready", 32'(m_stb), 6);
        chk(m_rd == 32'h0BAD_F00D, "R8 read after wait", m_rd, 32'h0BAD_F00D);
        cfg_write(8'h18, mk(0, 1, 0, 0, 0, 4'd1, 6'd1, 3'd1, 2'b10));
        run(2, 0, 32'h1357_9BDF, 5, 0);
        chk(m_stb == 7, "R9 two-stage ready", 32'(m_stb), 7);
        chk(m_hd == 2 && m_done == 1, "R8 hold after wait", 32'(m_hd), 2);

        // R8: ready already active gives the programmed minimum
        cfg_write(8'h18, mk(1, 1, 0, 0, 0, 4'd0, 6'd1, 3'd0, 2'b10));
        ext_rdy_n = 1'b0;
        repeat (3) @(negedge clk);
        run(2, 0, 32'h2468_ACE0, 0, 0);
        chk(m_stb == 2, "R8 minimum strobe", 32'(m_stb), 2);

        // R10: wait disabled, ready low then high
        cfg_write(8'h14, mk(1, 0, 0, 0, 0, 4'd0, 6'd2, 3'd0, 2'b10));
        run(1, 0, 32'h0000_0001, 0, 0);
        chk(m_stb == 3, "R10 ready low ignored", 32'(m_stb), 3);
        ext_rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        run(1, 1, 32'h0000_0002, 0, 0);
        chk(m_stb == 1 && m_done == 1, "R10 ready high ignored (write 0-len)", 32'(m_stb), 1);
        run(1, 0, 32'h0000_0003, 0, 0);
        chk(m_stb == 3 && m_done == 1, "R10 ready high ignored", 32'(m_stb), 3);

        // R11: request to region 3 while region 0 is busy
        cfg_write(8'h10, mk(0, 0, 0, 0, 0, 4'd1, 6'd4, 3'd1, 2'b10));
        run(0, 0, 32'hCAFE_0011, 0, 1);
        chk(!m_bad, "R11 other region stays high", 32'(m_bad), 0);
        chk(!m_idle_busy, "R11 req_idle low while busy", 32'(m_idle_busy), 0);
        begin
            bit extra;
            extra = 0;
            for (int k = 0; k < 6; k++) begin
                if (ext_cs_n != 4'hF || done) extra = 1;
                @(negedge clk);
            end
            chk(!extra, "R11 dropped request", 32'(extra), 0);
        end

        // R12: config change during a transfer affects only the next one
        cfg_write(8'h14, mk(0, 0, 0, 0, 0, 4'd0, 6'd4, 3'd0, 2'b10));
        inj_off = 8'h14;
        inj_cfg = mk(0, 0, 0, 0, 0, 4'd0, 6'd0, 3'd0, 2'b10);
        run(1, 0, 32'h7777_0000, 0, 2);
        chk(m_stb == 5, "R12 current transfer unchanged", 32'(m_stb), 5);
        cfg_addr = 8'h14; #1;
        chk(cfg_rdata == inj_cfg, "R12 write landed", cfg_rdata, inj_cfg);
        run(1, 0, 32'h7777_0001, 0, 0);
        chk(m_stb == 1, "R12 next transfer uses new word", 32'(m_stb), 1);

        finish_run();
    end

endmodule